// File: doc/BRIEF.md
# Eleven-Level Switched-Capacitor Inverter Gate Generator

This block turns a stream of signed reference samples into the ten gate drives of an eleven-level switched-capacitor inverter. The output steps from minus two and a half to plus two and a half times the DC input, in half-input steps. The block builds ten stacked triangular carriers from one shared up/down counter. Each clock it counts how many of those carriers the reference lies above, and that count is the output level index.

A decoder turns the level index into a fixed pattern of four active switches. The positive patterns also control when the capacitors charge. The negative patterns come from a parameter. A per-gate dead-time stage holds back each gate that is turning on for a programmable number of cycles. A gate that is turning off drops at once. The reference sine source and the power stage sit outside the block.

Top module: `mli_pwm_gate_gen`

## Requirements
- R1: One counter drives every carrier. After reset it reads 0 and rises by one each cycle up to CAR_MAX, then falls by one each cycle back to 0, and repeats. Carrier k (k = 0..9) equals -5*CAR_MAX + k*CAR_MAX + counter.
- R2: `level_o` is registered. One cycle after a reference sample is taken, it equals the number of carriers that the sample is strictly greater than. The carriers are evaluated with the counter value of that same cycle. Index 5 is the zero output, and each index step is half the input voltage.
- R3: A reference above 5*CAR_MAX gives index 10 (+2.5). A reference at or below -5*CAR_MAX gives index 0 (-2.5).
- R4: The settled gate vector uses bit n-1 for switch n. The positive levels map as follows: index 10 turns on switches 2, 4, 7 and 9; index 9 turns on 2, 3, 7 and 9; index 8 turns on 2, 4, 8 and 9; index 7 turns on 2, 3, 5 and 9; index 6 turns on 2, 6, 8 and 9; index 5 turns on 2, 3, 5 and 10.
- R5: Index l (0..4) takes its pattern from parameter NEG_GATES[10*l +: 10]. The default is the mirror of the positive levels: index 4 turns on 1, 6, 8 and 10; index 3 turns on 1, 3, 5 and 10; index 2 turns on 1, 4, 8 and 10; index 1 turns on 1, 3, 7 and 10; index 0 turns on 1, 4, 7 and 10.
- R6: Every settled pattern has exactly four active gates. At indices 7 and 5, switches 3 and 5 are on together.
- R7: When the level changes, each gate that turns off falls one cycle after `level_o` changes. Each gate that turns on rises `dead_i` cycles after that, provided its target holds. A gate whose target does not change keeps its value.
- R8: At no cycle are more than four gates active.
- R9: While the synchronous reset is held, all gates are low, `level_o` is 5 and the counter is 0. After release, the index-5 gates rise once the dead time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W | Signed reference sample |
| dead_i | input | DT_W | Turn-on delay in cycles |
| level_o | output | 4 | Registered level index, 0..10 |
| gate_o | output | 10 | Gate drives, bit n-1 for switch n |

## Verification
The assertions assume that the reference can take any signed value, including values beyond the carrier range. They also assume that `dead_i` may change at any cycle. The dead-gap property only applies to a rise whose previous-cycle delay was nonzero. The stimulus uses a slow full-range ramp, so that levels stay put long enough for dead time to expire. It adds clamped extremes on both sides for saturation, and seeded random samples both inside and outside the carrier span. `dead_i` is switched between zero and nonzero values during the run.

// File: rtl/mli_pkg.sv
package mli_pkg;
  localparam int N_SW     = 10;
  localparam int N_CAR    = 10;
  localparam int LVL_W    = 4;
  localparam int ZERO_LVL = 5;
  localparam int TOP_LVL  = 10;

  // positive and zero levels, bit n-1 drives switch n
  function automatic logic [N_SW-1:0] pos_pattern(input logic [LVL_W-1:0] lvl);
    logic [N_SW-1:0] p;
    case (lvl)
      4'd10:   p = 10'b0101001010;
      4'd9:    p = 10'b0101000110;
      4'd8:    p = 10'b0110001010;
      4'd7:    p = 10'b0100010110;
      4'd6:    p = 10'b0110100010;
      default: p = 10'b1000010110;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/mli_carrier.sv
module mli_carrier #(
  parameter int CAR_MAX = 200,
  localparam int CNT_W = $clog2(CAR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CAR_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q == TOP) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R1: counter stays within the triangle span
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);
  // R1: every step moves exactly one count
  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));
endmodule

// File: rtl/mli_level_cmp.sv
module mli_level_cmp
  import mli_pkg::*;
#(
  parameter int REF_W   = 12,
  parameter int CAR_MAX = 200,
  parameter int CNT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [LVL_W-1:0]        level_o
);
  localparam int CMP_W = REF_W + 2;
  localparam int BASE  = -5 * CAR_MAX;
  localparam int SPAN  = 5 * CAR_MAX;

  logic signed [CMP_W-1:0] ref_x;
  logic [N_CAR-1:0]        above;
  logic [LVL_W-1:0]        lvl_d, lvl_q;

  assign ref_x = CMP_W'(ref_i);

  for (genvar k = 0; k < N_CAR; k++) begin : g_car
    logic signed [CMP_W-1:0] car;
    assign car      = CMP_W'(BASE + k * CAR_MAX) + CMP_W'(cnt_i);
    assign above[k] = (ref_x > car);
  end

  always_comb begin
    lvl_d = '0;
    for (int k = 0; k < N_CAR; k++) lvl_d = lvl_d + LVL_W'(above[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= LVL_W'(ZERO_LVL);
    else     lvl_q <= lvl_d;
  end

  assign level_o = lvl_q;

  // R2: index never leaves 0..10
  a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LVL_W'(TOP_LVL));
  // R3: saturation above the top carrier
  a_r3_sat_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ref_x) > CMP_W'(SPAN)) |-> lvl_q == LVL_W'(TOP_LVL));
  // R3: saturation at or below the bottom carrier
  a_r3_sat_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ref_x) <= CMP_W'(-SPAN)) |-> lvl_q == '0);
endmodule

// File: rtl/mli_gate_map.sv
module mli_gate_map
  import mli_pkg::*;
#(
  parameter logic [5*N_SW-1:0] NEG_GATES = {10'b1010100001, 10'b1000010101,
                                            10'b1010001001, 10'b1001000101,
                                            10'b1001001001}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_i,
  output logic [N_SW-1:0]  pat_o
);
  always_comb begin
    if (level_i >= LVL_W'(ZERO_LVL)) pat_o = pos_pattern(level_i);
    else                             pat_o = NEG_GATES[N_SW*level_i +: N_SW];
  end

  // R6: every level drives exactly four switches
  a_r6_four_on: assert property (@(posedge clk) disable iff (rst)
    $countones(pat_o) == 4);
  // R6: switches 3 and 5 pair up for the joint capacitor charge levels
  a_r6_joint_charge: assert property (@(posedge clk) disable iff (rst)
    (level_i == 4'd7 || level_i == 4'd5) |-> (pat_o[2] && pat_o[4]));
endmodule

// File: rtl/mli_deadtime.sv
module mli_deadtime
  import mli_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] dead_i,
  input  logic [N_SW-1:0] tgt_i,
  output logic [N_SW-1:0] gate_o
);
  logic [N_SW-1:0] gate_q;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    logic [DT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
      if (rst || !tgt_i[i]) begin
        wait_q    <= '0;
        gate_q[i] <= 1'b0;
      end else if (!gate_q[i]) begin
        if (wait_q >= dead_i) gate_q[i] <= 1'b1;
        else                  wait_q    <= wait_q + 1'b1;
      end
    end

    // R7: a gate only turns on after its target was asserted
    a_r7_rise_needs_target: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_q[i]) |-> $past(tgt_i[i]));
    // R7: with a nonzero delay, the target has held for at least two cycles
    a_r7_dead_gap: assert property (@(posedge clk) disable iff (rst)
      ($rose(gate_q[i]) && $past(dead_i) != '0) |-> $past(tgt_i[i], 2));
    // R7: turn-off acts on the next edge
    a_r7_fast_off: assert property (@(posedge clk) disable iff (rst)
      !$past(tgt_i[i]) |-> !gate_q[i]);
  end

  assign gate_o = gate_q;

  // R8: never more than four switches at once
  a_r8_max_four: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_q) <= 4);
  // R9: reset clears every gate
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> gate_q == '0);
endmodule

// File: rtl/mli_pwm_gate_gen.sv
module mli_pwm_gate_gen
  import mli_pkg::*;
#(
  parameter int REF_W   = 12,
  parameter int CAR_MAX = 200,
  parameter int DT_W    = 6,
  parameter logic [5*N_SW-1:0] NEG_GATES = {10'b1010100001, 10'b1000010101,
                                            10'b1010001001, 10'b1001000101,
                                            10'b1001001001}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [LVL_W-1:0]        level_o,
  output logic [N_SW-1:0]         gate_o
);
  localparam int CNT_W = $clog2(CAR_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [LVL_W-1:0] level;
  logic [N_SW-1:0]  target;

  mli_carrier #(.CAR_MAX(CAR_MAX)) u_carrier (
    .clk(clk), .rst(rst), .cnt_o(cnt)
  );

  mli_level_cmp #(.REF_W(REF_W), .CAR_MAX(CAR_MAX), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .ref_i(ref_i), .cnt_i(cnt), .level_o(level)
  );

  mli_gate_map #(.NEG_GATES(NEG_GATES)) u_map (
    .clk(clk), .rst(rst), .level_i(level), .pat_o(target)
  );

  mli_deadtime #(.DT_W(DT_W)) u_dt (
    .clk(clk), .rst(rst), .dead_i(dead_i), .tgt_i(target), .gate_o(gate_o)
  );

  assign level_o = level;

  // R9: reset releases into the zero level
  a_r9_zero_after_reset: assert property (@(posedge clk)
    $past(rst) |-> level == LVL_W'(ZERO_LVL));
endmodule

// File: tb/mli_pwm_gate_gen_test.sv
module mli_pwm_gate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_W   = 12;
  localparam int CAR_MAX = 200;
  localparam int DT_W    = 6;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [REF_W-1:0] ref_r = '0;
  logic [DT_W-1:0]         dead_r = 6'd3;
  logic [3:0]              level_o;
  logic [9:0]              gate_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int       mc;
  bit       mup;
  int       mlev;
  bit [9:0] mg;
  int       mw [10];

  always #(CLK_PERIOD/2) clk = ~clk;

  mli_pwm_gate_gen #(.REF_W(REF_W), .CAR_MAX(CAR_MAX), .DT_W(DT_W)) uut (
    .clk(clk), .rst(rst), .ref_i(ref_r), .dead_i(dead_r),
    .level_o(level_o), .gate_o(gate_o)
  );

  // R4, R5: switch patterns per level
  function automatic bit [9:0] pattern(input int l);
    case (l)
      10: return 10'b0101001010;
      9:  return 10'b0101000110;
      8:  return 10'b0110001010;
      7:  return 10'b0100010110;
      6:  return 10'b0110100010;
      5:  return 10'b1000010110;
      4:  return 10'b1010100001;
      3:  return 10'b1000010101;
      2:  return 10'b1010001001;
      1:  return 10'b1001000101;
      default: return 10'b1001001001;
    endcase
  endfunction

  // R1, R2: count carriers strictly below the reference
  function automatic int exp_level(input int r, input int c);
    int n = 0;
    for (int k = 0; k < 10; k++)
      if (r > (-5*CAR_MAX + k*CAR_MAX + c)) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mc = 0; mup = 1'b1; mlev = 5; mg = '0;
    for (int i = 0; i < 10; i++) mw[i] = 0;
  endtask

  // one cycle: drive at negedge, advance model across posedge, check at next negedge
  task automatic step(input int r, input int d);
    int       nlev;
    bit [9:0] tg;
    ref_r  = REF_W'(r);
    dead_r = DT_W'(d);
    nlev = exp_level(r, mc);
    tg = pattern(mlev);
    for (int i = 0; i < 10; i++) begin
      if (!tg[i]) begin
        mg[i] = 1'b0; mw[i] = 0;
      end else if (!mg[i]) begin
        if (mw[i] >= d) mg[i] = 1'b1;
        else            mw[i] = mw[i] + 1;
      end
    end
    mlev = nlev;
    if (mup) begin
      if (mc == CAR_MAX) begin mup = 1'b0; mc = mc - 1; end
      else mc = mc + 1;
    end else begin
      if (mc == 0) begin mup = 1'b1; mc = mc + 1; end
      else mc = mc - 1;
    end
    @(posedge clk);
    @(negedge clk);
    if (r > 5*CAR_MAX || r <= -5*CAR_MAX)
      check(level_o == 4'(mlev), "R3 saturated level", int'(level_o), mlev);
    else
      check(level_o == 4'(mlev), "R2 level index", int'(level_o), mlev);
    if (mg == pattern(mlev)) begin
      check(gate_o == mg, (mlev >= 5) ? "R4 positive pattern" : "R5 negative pattern",
            int'(gate_o), int'(mg));
      check($countones(gate_o) == 4, "R6 four active", $countones(gate_o), 4);
      if (mlev == 7 || mlev == 5)
        check(gate_o[2] && gate_o[4], "R6 joint charge S3/S5", int'(gate_o), int'(mg));
    end else begin
      check(gate_o == mg, "R7 dead time transition", int'(gate_o), int'(mg));
    end
    check($countones(gate_o) <= 4, "R8 at most four", $countones(gate_o), 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(gate_o == '0, "R9 gates low in reset", int'(gate_o), 0);
    check(level_o == 4'd5, "R9 zero level in reset", int'(level_o), 5);
    rst = 1'b0;
    // R9: release into zero pattern after dead time
    for (int n = 0; n < 8; n++) step(0, 3);
    check(gate_o == pattern(5), "R9 zero pattern after release", int'(gate_o), int'(pattern(5)));
    // R3: clamped extremes
    for (int n = 0; n < 10; n++) step(2047, 3);
    for (int n = 0; n < 10; n++) step(-2048, 3);
    for (int n = 0; n < 6; n++)  step(-1000, 2);
    for (int n = 0; n < 6; n++)  step(1001, 0);
    // R1, R2, R4, R5, R7: slow full ramp up and down
    for (int r = -1100; r <= 1100; r++) step(r, 4);
    for (int r = 1100; r >= -1100; r -= 2) step(r, 0);
    // random samples, occasional delay changes
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(2600, 0)) - 1300;
      int d = (n / 500) % 3 == 0 ? 0 : int'(n / 500);
      step(r, d);
    end
    // R9: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(gate_o == '0, "R9 gates cleared by reset", int'(gate_o), 0);
    check(level_o == 4'd5, "R9 level reset", int'(level_o), 5);
    model_reset();
    rst = 1'b0;
    for (int n = 0; n < 6; n++) step(0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule